// File: doc/BRIEF.md
# Front-End Control Bus Serial Slave

This block is the digital core of a slave on a two-wire front-end control bus: one clock line driven by the bus master and one data line that both sides share. Both bus lines are oversampled with the local system clock. The block waits for a start condition and then shifts in a 13-bit command frame. That frame holds a 4-bit slave identifier, an 8-bit command and an odd parity bit. From the command it either issues a short register-0 write whose seven data bits sit inside the command itself, collects a separate 9-bit data frame for an ordinary register write, or asks the surrounding logic for a register value and sends that value back on the data line.

The data line appears as three core-side signals (input, output value, output enable), so the pad driver is left outside the block. The register file is also outside. It sees a one-cycle write strobe with address and data, and a one-cycle read request with an address. It must present the read value on `rd_data` before the first read data bit goes out. The slave identifier resets to `USID_RST` and takes its new value from the low four data bits of any accepted write to register `USID_REG`.

Top module: `rffe_slave`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `wr_stb`, `rd_req` and `sdata_oe` are all 0.
- R2: A start condition is a falling edge on the data line while the bus clock is low. Clock pulses that arrive without a preceding start condition cause no strobe and no request.
- R3: A command frame is sampled MSB first, one bit on each bus clock falling edge: ID[3:0], command[7:0], parity. When command bit 7 is 1 the frame is a register-0 write and produces one `wr_stb` pulse with `wr_addr`=0 and `wr_data`={0, command[6:0]}.
- R4: Command[7:5]=010 is a register write to address command[4:0]. The next 9 bits form a data frame (data[7:0] MSB first, then parity), and the write produces one `wr_stb` pulse carrying that address and data.
- R5: Each frame's parity bit makes the count of ones in the frame odd. A command frame that breaks this produces no strobe and no request.
- R6: A register write whose data frame breaks odd parity produces no strobe.
- R7: A frame whose ID is neither the current slave ID nor 0000 produces no strobe and no request.
- R8: ID 0000 is accepted for both write forms. A read addressed with 0000 gives no request and leaves the data line undriven.
- R9: Command[7:5]=011 is a read. It produces one `rd_req` pulse with `rd_addr`=command[4:0]. The first bus clock after the command is a park cycle. On each of the next nine rising edges the block drives `rd_data` MSB first and then its odd parity bit. On the rising edge after that it drives 0, and it releases the line on the following falling edge.
- R10: A read command with a parity error gives no request and leaves the data line undriven.
- R11: The slave ID resets to 1010. An accepted write to register `USID_REG` loads data[3:0] as the new ID, and from then on the old ID is not answered.
- R12: Commands with command[7:5] of 000 or 001 produce no strobe, no request and no drive.
- R13: A start condition in the middle of a frame discards the bits collected so far and begins a new command frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Bus clock from the master |
| sdata_in | input | 1 | Sampled level of the bus data line |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 8 | Register data of the write |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 5 | Register address of the read |
| rd_data | input | 8 | Register value returned by the register file |
| sdata_out | output | 1 | Value the slave drives onto the data line |
| sdata_oe | output | 1 | Data line output enable |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, ID reset value 1010 and ID register 31. With ID register 31, reprogramming the ID goes through the same register-write path that the vector table already exercises. With a bus clock half-period of ten system cycles, every synchronized edge lands well inside its bit. Reads are clocked at double that half-period, which checks that the returned bits stay steady for a full slow clock period.

// File: rtl/rffe_slave.sv
module rffe_slave #(
  parameter logic [3:0] USID_RST    = 4'b1010,
  parameter logic [4:0] USID_REG    = 5'd31,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       sdata_in,
  output logic       wr_stb,
  output logic [4:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic [4:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       sdata_out,
  output logic       sdata_oe
);

  localparam int CMD_LAST = 12;
  localparam int DAT_LAST = 8;
  localparam int RD_LOAD  = 1;
  localparam int RD_DONE  = 11;

  typedef enum logic [1:0] {IDLE, CMD, WDAT, RDRV} st_t;

  st_t              st;
  logic [3:0]       cnt;
  logic [11:0]      sh;
  logic [3:0]       id;
  logic [9:0]       out_sh;
  logic [SYNC_STAGES:0] sc_p, sd_p;

  wire sc_now = sc_p[SYNC_STAGES-1];
  wire sc_old = sc_p[SYNC_STAGES];
  wire sd_now = sd_p[SYNC_STAGES-1];
  wire sd_old = sd_p[SYNC_STAGES];
  wire s_fall = sc_old & ~sc_now;
  wire s_rise = ~sc_old & sc_now;
  wire ssc    = sd_old & ~sd_now & ~sc_now & ~sdata_oe;

  wire [12:0] frame = {sh, sd_now};
  wire [3:0]  f_sa  = frame[12:9];
  wire [7:0]  f_cmd = frame[8:1];
  wire        f_par = ^frame;
  wire [8:0]  dfr   = {sh[7:0], sd_now};
  wire        d_par = ^dfr;
  wire        hit_w = f_par && (f_sa == id || f_sa == 4'd0);
  wire        hit_r = f_par && f_sa == id && f_sa != 4'd0;

  assign sdata_out = sdata_oe & out_sh[9];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_p     <= '0;
      sd_p     <= '0;
      st       <= IDLE;
      cnt      <= '0;
      sh       <= '0;
      id       <= USID_RST;
      out_sh   <= '0;
      sdata_oe <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      sc_p   <= {sc_p[SYNC_STAGES-1:0], sclk};
      sd_p   <= {sd_p[SYNC_STAGES-1:0], sdata_in};
      wr_stb <= 1'b0;
      rd_req <= 1'b0;
      if (ssc) begin
        st  <= CMD;
        cnt <= '0;
      end else begin
        case (st)
          CMD: if (s_fall) begin
            sh  <= frame[11:0];
            cnt <= cnt + 4'd1;
            if (cnt == CMD_LAST[3:0]) begin
              st <= IDLE;
              if (f_cmd[7]) begin
                if (hit_w) begin
                  wr_stb  <= 1'b1;
                  wr_addr <= '0;
                  wr_data <= {1'b0, f_cmd[6:0]};
                end
              end else if (f_cmd[7:5] == 3'b010) begin
                if (hit_w) begin
                  st      <= WDAT;
                  cnt     <= '0;
                  wr_addr <= f_cmd[4:0];
                end
              end else if (f_cmd[7:5] == 3'b011 && hit_r) begin
                rd_req  <= 1'b1;
                rd_addr <= f_cmd[4:0];
                st      <= RDRV;
                cnt     <= '0;
              end
            end
          end
          WDAT: if (s_fall) begin
            sh  <= frame[11:0];
            cnt <= cnt + 4'd1;
            if (cnt == DAT_LAST[3:0]) begin
              st <= IDLE;
              if (d_par) begin
                wr_stb  <= 1'b1;
                wr_data <= dfr[8:1];
                if (wr_addr == USID_REG) id <= dfr[4:1];
              end
            end
          end
          RDRV: begin
            if (s_rise && cnt != RD_DONE[3:0]) begin
              cnt <= cnt + 4'd1;
              if (cnt == RD_LOAD[3:0]) begin
                out_sh   <= {rd_data, ~^rd_data, 1'b0};
                sdata_oe <= 1'b1;
              end else if (cnt > RD_LOAD[3:0]) begin
                out_sh <= {out_sh[8:0], 1'b0};
              end
            end
            if (s_fall && cnt == RD_DONE[3:0]) begin
              sdata_oe <= 1'b0;
              st       <= IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module rffe_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       rd_req,
  input logic       sdata_oe,
  input logic [3:0] cmd_sa,
  input logic [3:0] id
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_stb && !rd_req && !sdata_oe));

  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9
  rd_park_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (!rd_req && !sdata_oe));

  // R9
  no_wr_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !wr_stb);

  // R8
  rd_own_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ($past(cmd_sa) == $past(id) && $past(cmd_sa) != 4'd0));

endmodule

bind rffe_slave rffe_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .rd_req   (rd_req),
  .sdata_oe (sdata_oe),
  .cmd_sa   (frame[12:9]),
  .id       (id)
);

// File: tb/tb_rffe_slave.sv
module tb_rffe_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       wr_stb, rd_req, sdata_out, sdata_oe;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int tests = 0, fails = 0, hp = 10;
  int wr_cnt = 0, rd_cnt = 0;
  logic [4:0] last_wa;
  logic [7:0] last_wd;
  logic       oe_seen = 1'b0;
  logic [8:0] rbits;
  logic       park_ok;

  always #2 clk = ~clk;

  assign rd_data = {rd_addr, 3'b101} ^ 8'h3C;

  rffe_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  always @(negedge clk) begin
    if (wr_stb) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (rd_req) rd_cnt++;
    if (sdata_oe) oe_seen = 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b);
    @(negedge clk); sclk = 1'b1; sdata = b;
    repeat (hp) @(negedge clk);
    sclk = 1'b0;
    repeat (hp) @(negedge clk);
  endtask

  task automatic ssc();
    @(negedge clk); sclk = 1'b0; sdata = 1'b1;
    repeat (hp) @(negedge clk);
    sdata = 1'b0;
    repeat (hp) @(negedge clk);
  endtask

  task automatic run(input logic [1:0] kind, input logic [3:0] sa, input logic [4:0] a,
                     input logic [7:0] d, input logic bc, input logic bd, input logic do_ssc);
    logic [7:0]  c;
    logic [12:0] f;
    logic [8:0]  df;
    case (kind)
      2'd0: c = {1'b1, d[6:0]};
      2'd1: c = {3'b010, a};
      2'd2: c = {3'b011, a};
      default: c = {3'b000, a};
    endcase
    f = {sa, c, 1'b0};
    f[0] = (~^f[12:1]) ^ bc;
    df = {d, (~^d) ^ bd};
    oe_seen = 1'b0;
    hp = 10;
    if (do_ssc) ssc();
    for (int i = 12; i >= 0; i--) bit_cyc(f[i]);
    if (kind == 2'd1) for (int i = 8; i >= 0; i--) bit_cyc(df[i]);
    if (kind == 2'd2) begin
      hp = 20;
      park_ok = 1'b1;
      for (int i = 0; i <= 10; i++) begin
        @(negedge clk); sclk = 1'b1; sdata = 1'b0;
        repeat (hp - 1) @(negedge clk);
        if (i >= 1 && i <= 9) rbits[9 - i] = sdata_out;
        if (i == 10 && (sdata_oe !== 1'b1 || sdata_out !== 1'b0)) park_ok = 1'b0;
        @(negedge clk); sclk = 1'b0;
        repeat (hp) @(negedge clk);
      end
      hp = 10;
    end else begin
      bit_cyc(1'b0);
    end
    repeat (8) @(negedge clk);
  endtask

  localparam logic [21:0] VEC [0:11] = '{
    {2'd0, 4'hA, 5'd0,  8'h55, 1'b0, 1'b0, 1'b1},
    {2'd1, 4'hA, 5'd3,  8'h5C, 1'b0, 1'b0, 1'b1},
    {2'd1, 4'h0, 5'd4,  8'hA1, 1'b0, 1'b0, 1'b1},
    {2'd1, 4'h5, 5'd6,  8'h77, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'hA, 5'd0,  8'h2A, 1'b1, 1'b0, 1'b0},
    {2'd1, 4'hA, 5'd9,  8'hC3, 1'b0, 1'b1, 1'b0},
    {2'd2, 4'hA, 5'd7,  8'h00, 1'b0, 1'b0, 1'b1},
    {2'd2, 4'h0, 5'd7,  8'h00, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'hA, 5'd18, 8'h00, 1'b1, 1'b0, 1'b0},
    {2'd3, 4'hA, 5'd2,  8'h00, 1'b0, 1'b0, 1'b0},
    {2'd0, 4'h3, 5'd0,  8'h11, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'hA, 5'd31, 8'h00, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";   1: return "R4";   2: return "R8";  3: return "R7";
      4: return "R5";   5: return "R6";   6: return "R9";  7: return "R8";
      8: return "R10";  9: return "R12"; 10: return "R7"; default: return "R9";
    endcase
  endfunction

  task automatic check_rd(input string tag, input logic [4:0] a, input int r0);
    logic [7:0] rv;
    rv = {a, 3'b101} ^ 8'h3C;
    chk(rd_cnt - r0 == 1, {tag, " rd_req"}, rd_cnt - r0, 1);
    chk(rbits == {rv, ~^rv}, {tag, " read bits"}, rbits, {rv, ~^rv});
    chk(park_ok, {tag, " park drive"}, park_ok, 1);
    chk(sdata_oe == 1'b0, {tag, " release"}, sdata_oe, 0);
  endtask

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    chk(!wr_stb && !rd_req && !sdata_oe, "R1 in reset", {wr_stb, rd_req, sdata_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_stb && !rd_req && !sdata_oe, "R1 after reset", {wr_stb, rd_req, sdata_oe}, 0);
    repeat (5) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] k; logic [3:0] sa; logic [4:0] a; logic [7:0] d; logic bc, bd, ex;
      {k, sa, a, d, bc, bd, ex} = VEC[i];
      w0 = wr_cnt; r0 = rd_cnt;
      run(k, sa, a, d, bc, bd, 1'b1);
      if (k == 2'd2) begin
        if (ex) check_rd(tag_of(i), a, r0);
        else begin
          chk(rd_cnt == r0, {tag_of(i), " no rd_req"}, rd_cnt - r0, 0);
          chk(!oe_seen, {tag_of(i), " no drive"}, oe_seen, 0);
        end
      end else begin
        chk(wr_cnt - w0 == int'(ex), {tag_of(i), " strobe count"}, wr_cnt - w0, ex);
        chk(rd_cnt == r0 && !oe_seen, {tag_of(i), " no read side"}, rd_cnt - r0, 0);
        if (ex) begin
          chk(last_wa == ((k == 2'd0) ? 5'd0 : a), {tag_of(i), " addr"}, last_wa, a);
          chk(last_wd == ((k == 2'd0) ? {1'b0, d[6:0]} : d), {tag_of(i), " data"}, last_wd, d);
        end
      end
    end

    // R2: valid register-0 frame with no start condition
    w0 = wr_cnt;
    run(2'd0, 4'hA, 5'd0, 8'h33, 1'b0, 1'b0, 1'b0);
    chk(wr_cnt == w0, "R2 no start", wr_cnt - w0, 0);

    // R13: abort mid-frame with a new start condition
    w0 = wr_cnt;
    hp = 10;
    ssc();
    for (int i = 0; i < 5; i++) bit_cyc(i[0]);
    run(2'd0, 4'hA, 5'd0, 8'h4E, 1'b0, 1'b0, 1'b1);
    chk(wr_cnt - w0 == 1, "R13 restart count", wr_cnt - w0, 1);
    chk(last_wd == 8'h4E, "R13 restart data", last_wd, 8'h4E);

    // R11: reprogram the slave ID to 0011
    w0 = wr_cnt;
    run(2'd1, 4'hA, 5'd31, 8'hF3, 1'b0, 1'b0, 1'b1);
    chk(wr_cnt - w0 == 1 && last_wa == 5'd31, "R11 id write", last_wa, 31);
    w0 = wr_cnt;
    run(2'd0, 4'hA, 5'd0, 8'h12, 1'b0, 1'b0, 1'b1);
    chk(wr_cnt == w0, "R11 old id ignored", wr_cnt - w0, 0);
    run(2'd0, 4'h3, 5'd0, 8'h2B, 1'b0, 1'b0, 1'b1);
    chk(wr_cnt - w0 == 1 && last_wd == 8'h2B, "R11 new id write", last_wd, 8'h2B);
    r0 = rd_cnt;
    run(2'd2, 4'h3, 5'd5, 8'h00, 1'b0, 1'b0, 1'b1);
    check_rd("R11", 5'd5, r0);
    w0 = wr_cnt;
    run(2'd1, 4'h0, 5'd8, 8'h69, 1'b0, 1'b0, 1'b1);
    chk(wr_cnt - w0 == 1 && last_wd == 8'h69, "R8 broadcast after id change", last_wd, 8'h69);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule